// File: doc/BRIEF.md
# Programmable Baud Pulse Generator

This block turns a fast source clock into a pulse stream at sixteen times a UART's bit rate. A CPU register interface writes a 16-bit divisor as two byte-wide latches, and a down-counter then raises a one-period pulse once every N source clock periods. The output is a plain data signal for the serial logic to use as a sampling enable. It is not a derived clock.

The source clock is gated by a clock enable, so each enabled cycle is one source period. A small state machine sequences the counter. In the LOAD state the first enabled tick copies the latched divisor into the counter and moves to COUNT. In COUNT every enabled tick either steps the counter down or, at the terminal value, pulses and reloads. COUNT returns to itself. Only a synchronous reset brings the machine back to LOAD.

A divisor written while a count is running does not restart that count. The new value is used from the next reload. A divisor of zero gives a period of 65536 ticks. A divisor of one keeps the output high all the time.

Top module: `baud_pulse_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the output goes low after that edge, both divisor bytes are cleared to zero, and the machine enters LOAD.
- R2: A write with `wr_en` high stores `wr_data` into the low divisor byte (bits 7:0) when `wr_sel` is 0, and into the high divisor byte (bits 15:8) when `wr_sel` is 1. The write takes effect at that clock edge whether or not `clk_en` is high.
- R3: For a divisor N from 2 to 65535, `baud_pulse` is high for exactly one enabled tick, and consecutive rising points are N enabled ticks apart.
- R4: With a divisor of 1, `baud_pulse` stays high on every enabled tick.
- R5: A divisor of 0 gives pulses 65536 enabled ticks apart.
- R6: After reset, the first enabled tick (LOAD) loads the counter. The first pulse appears after the N-th enabled tick that follows, which is 1+N ticks after reset release (1+65536 for N=0).
- R7: A divisor write during a count leaves the current period at its old length. The new divisor sets the length of the following period, because the counter takes the latched value only at its terminal tick.
- R8: While `clk_en` is low, neither the counter nor `baud_pulse` changes. Counting resumes with the ticks still remaining.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous master reset, active high |
| clk_en | input | 1 | Source clock enable; each high cycle is one source period |
| wr_en | input | 1 | Divisor byte write strobe |
| wr_sel | input | 1 | Byte select: 0 low byte, 1 high byte |
| wr_data | input | 8 | Divisor byte value |
| baud_pulse | output | 1 | 16x baud pulse, one source period high |

## Verification
The pulse is registered, so it shows in the sample that follows the edge of the terminal tick. The bench therefore measures every spacing as the number of edges between two high samples, each sample taken 1 ns after an edge. Divisor writes are made with `clk_en` held low, so they land between ticks. The first period after a write is then expected at the old length and the one after it at the new length (R7). After reset release, the first pulse is due 1+N edges later, because one extra edge is spent in LOAD. While `clk_en` is low, the output is sampled on every paused edge. On resume, only the remaining ticks are expected to pass before the next pulse.

// File: rtl/bpg_pkg.sv
package bpg_pkg;

    // Sequencer states of the baud pulse generator.
    typedef enum logic [0:0] {
        ST_LOAD  = 1'b0,   // first enabled tick copies the divisor into the counter
        ST_COUNT = 1'b1    // counting down; terminal tick pulses and reloads
    } bpg_state_e;

    // Number of source ticks represented by a divisor value (zero means full range).
    function automatic int unsigned bpg_period(input int unsigned div, input int unsigned width);
        return (div == 0) ? (32'd1 << width) : div;
    endfunction

endpackage

// File: rtl/bpg_div_latch.sv
module bpg_div_latch #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 2,
    parameter int SEL_W     = 1,
    localparam int DIV_W    = BYTE_W * NUM_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [DIV_W-1:0]  divisor
);

    // One byte-wide latch per divisor slice, byte 0 least significant.
    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
        logic [BYTE_W-1:0] byte_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                byte_q <= wr_data;
            end
        end

        assign divisor[g*BYTE_W +: BYTE_W] = byte_q;
    end

endmodule

// File: rtl/bpg_down_counter.sv
module bpg_down_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         at_term
);

    // A load of zero wraps through the full range before reaching one.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            if (load) begin
                cnt <= load_val;
            end else begin
                cnt <= cnt - W'(1);
            end
        end
    end

    assign at_term = (cnt == W'(1));

endmodule

// File: rtl/bpg_ctrl.sv
module bpg_ctrl
    import bpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       at_term,
    output bpg_state_e state,
    output logic       load,
    output logic       pulse
);

    bpg_state_e state_nx;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_LOAD;
        end else if (tick) begin
            state <= state_nx;
        end
    end

    // Next state and counter load request.
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        unique case (state)
            ST_LOAD: begin
                state_nx = ST_COUNT;
                load     = tick;
            end
            ST_COUNT: begin
                state_nx = ST_COUNT;
                load     = tick && at_term;
            end
        endcase
    end

    // Output register: high for the tick that follows a terminal count.
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= 1'b0;
        end else if (tick) begin
            unique case (state)
                ST_LOAD:  pulse <= 1'b0;
                ST_COUNT: pulse <= at_term;
            endcase
        end
    end

endmodule

// File: rtl/baud_pulse_gen.sv
module baud_pulse_gen
    import bpg_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 2,
    localparam int DIV_W    = BYTE_W * NUM_BYTES,
    localparam int SEL_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              baud_pulse
);

    logic [DIV_W-1:0] div_val;
    logic [DIV_W-1:0] cnt_val;
    logic             cnt_term;
    logic             cnt_load;
    bpg_state_e       fsm_state;

    bpg_div_latch #(
        .BYTE_W   (BYTE_W),
        .NUM_BYTES(NUM_BYTES),
        .SEL_W    (SEL_W)
    ) div_latch_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_data(wr_data),
        .divisor(div_val)
    );

    bpg_down_counter #(
        .W(DIV_W)
    ) counter_i (
        .clk     (clk),
        .rst     (rst),
        .tick    (clk_en),
        .load    (cnt_load),
        .load_val(div_val),
        .cnt     (cnt_val),
        .at_term (cnt_term)
    );

    bpg_ctrl ctrl_i (
        .clk    (clk),
        .rst    (rst),
        .tick   (clk_en),
        .at_term(cnt_term),
        .state  (fsm_state),
        .load   (cnt_load),
        .pulse  (baud_pulse)
    );

endmodule

// File: rtl/bpg_checker.sv
module bpg_checker
    import bpg_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 1,
    parameter int DIV_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              clk_en,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [BYTE_W-1:0] wr_data,
    input logic              baud_pulse,
    input logic [DIV_W-1:0]  cnt_val,
    input logic              cnt_term,
    input logic [DIV_W-1:0]  div_val,
    input bpg_state_e        fsm_state
);

    localparam int TOP_SEL = DIV_W / BYTE_W - 1;

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!baud_pulse && div_val == '0 && fsm_state == ST_LOAD));

    assert_low_byte_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_W'(0)) |=> div_val[BYTE_W-1:0] == $past(wr_data));

    assert_high_byte_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_W'(TOP_SEL)) |=> div_val[DIV_W-1:DIV_W-BYTE_W] == $past(wr_data));

    assert_single_high_R3: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !cnt_term) |=> !baud_pulse);

    assert_pulse_source_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(baud_pulse) |-> $past(clk_en && cnt_term && fsm_state == ST_COUNT));

    assert_div1_steady_R4: assert property (@(posedge clk) disable iff (rst)
        (clk_en && fsm_state == ST_COUNT && cnt_term && div_val == DIV_W'(1))
        |=> (baud_pulse && cnt_term));

    assert_zero_reload_R5: assert property (@(posedge clk) disable iff (rst)
        (clk_en && fsm_state == ST_COUNT && cnt_term && div_val == '0) |=> cnt_val == '0);

    assert_first_load_R6: assert property (@(posedge clk) disable iff (rst)
        (clk_en && fsm_state == ST_LOAD) |=> (fsm_state == ST_COUNT && cnt_val == $past(div_val)));

    assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
        (clk_en && fsm_state == ST_COUNT && cnt_term) |=> cnt_val == $past(div_val));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> ($stable(baud_pulse) && $stable(cnt_val)));

endmodule

bind baud_pulse_gen bpg_checker #(
    .BYTE_W(BYTE_W),
    .SEL_W (SEL_W),
    .DIV_W (DIV_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .clk_en    (clk_en),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .baud_pulse(baud_pulse),
    .cnt_val   (cnt_val),
    .cnt_term  (cnt_term),
    .div_val   (div_val),
    .fsm_state (fsm_state)
);

// File: tb/baud_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module baud_pulse_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clk_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [0:0] wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       baud_pulse;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    baud_pulse_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .clk_en    (clk_en),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .baud_pulse(baud_pulse)
    );

    function automatic int period_of(input int d);
        return (d == 0) ? 65536 : d;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic write_byte(input bit sel, input logic [7:0] val);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = val;
        step();
        wr_en   = 1'b0;
    endtask

    // Writes both bytes with ticks paused so no terminal falls between them.
    task automatic program_div(input int d);
        logic [15:0] dv;
        dv = d[15:0];
        clk_en = 1'b0;
        write_byte(1'b0, dv[7:0]);
        write_byte(1'b1, dv[15:8]);
        clk_en = 1'b1;
    endtask

    task automatic count_to_high(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!baud_pulse && n < 70000);
    endtask

    task automatic gap_check(input int exp, input string req);
        int n;
        count_to_high(n);
        check(n == exp, req, n, exp);
    endtask

    task automatic change_div(input int d_old, input int d_new, input string req);
        int n;
        count_to_high(n);
        program_div(d_new);
        gap_check(period_of(d_old), {req, "/R7 old length"});
        gap_check(period_of(d_new), req);
    endtask

    initial begin
        int n;
        int cur;
        int unsigned seed_set;
        seed_set = $urandom(32'd4711);

        // R1: reset holds the output low.
        for (int i = 0; i < 3; i++) begin
            step();
            check(baud_pulse == 1'b0, "R1 low in reset", int'(baud_pulse), 0);
        end
        rst = 1'b0;

        // R6/R1: cleared latch means a 65536 first period; write of 3 mid-count obeys R7.
        for (int i = 0; i < 10; i++) begin
            step();
            if (i == 9) check(baud_pulse == 1'b0, "R6 low before first pulse", int'(baud_pulse), 0);
        end
        program_div(3);
        count_to_high(n);
        check(n == 65537 - 10, "R6/R1/R7 first pulse after reset", n, 65537 - 10);
        gap_check(3, "R3 divisor 3 after R7 reload");
        gap_check(3, "R3 divisor 3 repeat");

        // R2 high byte exercised with 0x0123.
        change_div(3, 16'h0123, "R2/R3 divisor 0x0123");

        // R4: divisor 1 is continuously high.
        change_div(16'h0123, 1, "R4 divisor 1");
        for (int i = 0; i < 4; i++) begin
            step();
            check(baud_pulse == 1'b1, "R4 steady high", int'(baud_pulse), 1);
        end

        // R1: reset mid-run forces low; then first pulse after load is 1+N.
        rst = 1'b1;
        step();
        check(baud_pulse == 1'b0, "R1 reset mid-run", int'(baud_pulse), 0);
        rst = 1'b0;
        program_div(2);
        gap_check(3, "R6 first pulse 1+N after reset");
        change_div(2, 5, "R3 divisor 5");

        // R8: pause while high, then while low.
        count_to_high(n);
        clk_en = 1'b0;
        for (int i = 0; i < 7; i++) begin
            step();
            check(baud_pulse == 1'b1, "R8 hold high", int'(baud_pulse), 1);
        end
        clk_en = 1'b1;
        gap_check(5, "R8 resume after high pause");
        step();
        step();
        clk_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            step();
            check(baud_pulse == 1'b0, "R8 hold low", int'(baud_pulse), 0);
        end
        clk_en = 1'b1;
        gap_check(3, "R8 resume with remaining ticks");

        // R3: random divisors.
        cur = 5;
        for (int k = 0; k < 6; k++) begin
            int d;
            d = int'($urandom_range(2, 60));
            change_div(cur, d, "R3 random divisor");
            cur = d;
        end
        change_div(cur, 16'h1234, "R3/R2 large divisor");
        change_div(16'h1234, 2, "R3 divisor 2");

        // R5: zero divisor.
        change_div(2, 0, "R5 divisor 0");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule